// File: doc/BRIEF.md
# Delay Line Tap Stepper

This controller walks two incremental delay lines, one on the read path and one on the write path, from their power-on tap positions to requested tap settings. Each line only understands reset, chip-enable, an increment-direction flag and a shared step clock. The controller therefore issues every change as a pulse of three equal phases, with the step clock high only in the middle phase. It also keeps its own copy of each line's tap position.

A start pulse captures both targets. Both lines are then reset together with one step-clock pulse, which puts the read line at tap 16 and the write line at tap 32. After that the read line is moved one tap per pulse until it matches its target. Only then does the write line move toward its own target. When both lines match, a single-cycle done pulse is raised. Each phase lasts a parameterised number of system clocks. This gives the delay elements setup and hold margin around the step-clock edges.

Top module: `delay_tap_stepper`

## Requirements
- R1: Out of reset, every strobe output and done_o are low, rd_tap_o reads 16 and wr_tap_o reads 32.
- R2: A start pulse sampled while idle begins a reset pulse. During that pulse rd_rst_o and wr_rst_o are both high for three phases, and step_clk_o is high during the middle phase only. Afterwards rd_tap_o is 16 and wr_tap_o is 32.
- R3: Every phase lasts exactly PHASE_CLKS clock cycles, so each step_clk_o high period is PHASE_CLKS cycles long.
- R4: The read line reaches its target before any write step occurs. wr_ce_o is never high while the read line differs from its target, and rd_ce_o and wr_ce_o are never high together.
- R5: A step drives the moving line's chip-enable for the whole three-phase pulse, with inc_o=1 when moving up and inc_o=0 when moving down. The tracked tap changes by exactly one at the end of the pulse.
- R6: Steps occur only while a line's tap differs from its target, and a line already at its target takes no step. Done follows the start sample by 3*PHASE_CLKS*(1+|rd_target-16|+|wr_target-32|)+2 cycles.
- R7: done_o is high for exactly one cycle, and at that time rd_tap_o and wr_tap_o equal the captured targets.
- R8: A start pulse received while a sequence is running is ignored. Target inputs that change after the start sample have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| rd_target_i | input | TAP_W | Requested read-line tap |
| wr_target_i | input | TAP_W | Requested write-line tap |
| rd_rst_o | output | 1 | Read delay line reset |
| wr_rst_o | output | 1 | Write delay line reset |
| rd_ce_o | output | 1 | Read delay line chip-enable |
| wr_ce_o | output | 1 | Write delay line chip-enable |
| inc_o | output | 1 | Step direction, 1 = up |
| step_clk_o | output | 1 | Shared delay-line step clock |
| rd_tap_o | output | TAP_W | Tracked read-line tap |
| wr_tap_o | output | TAP_W | Tracked write-line tap |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can coincide. A start pulse can land in the same cycle as the controller finishing a read-line step while it is busy. A change of the target inputs can also fall in the middle of that sequence. The bench provokes both by pulsing start with different targets partway through a run. It judges the outcome by checking three things: exactly one done appears, the final taps and the modelled delay-line counters equal the first targets, and the latency matches the first request alone. A delay-line model counts step-clock edges according to reset, chip-enable and direction. That model confirms that no write step starts before the read line has settled.

// File: rtl/delay_step_pkg.sv
package delay_step_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_RD,
    ST_WR,
    ST_FIN
  } step_state_e;

  localparam logic [1:0] PH_SETUP = 2'd0;
  localparam logic [1:0] PH_CLK   = 2'd1;
  localparam logic [1:0] PH_HOLD  = 2'd2;
endpackage

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int PHASE_CLKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  output logic [1:0] phase_o,
  output logic       last_o
);
  import delay_step_pkg::*;

  localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PHASE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       phase_q;
  logic             phase_end;

  assign phase_end = run_i && (cnt_q == CNT_MAX);
  assign last_o    = phase_end && (phase_q == PH_HOLD);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_SETUP;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= PH_SETUP;
    end else if (phase_end) begin
      cnt_q   <= '0;
      phase_q <= (phase_q == PH_HOLD) ? PH_SETUP : phase_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != 2'd3) && (cnt_q <= CNT_MAX));

  // R3
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !phase_end |=> (phase_q == $past(phase_q)) || !$past(run_i));
endmodule

// File: rtl/tap_track.sv
module tap_track #(
  parameter int TAP_W   = 6,
  parameter int RST_VAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [TAP_W-1:0] target_i,
  input  logic             load_i,
  input  logic             step_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             match_o,
  output logic             up_o
);
  localparam logic [TAP_W-1:0] RST_TAP = TAP_W'(RST_VAL);

  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] tgt_q;

  assign match_o = (tap_q == tgt_q);
  assign up_o    = (tap_q < tgt_q);
  assign tap_o   = tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= RST_TAP;
    end else if (cap_i) begin
      tgt_q <= target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q <= RST_TAP;
    end else if (load_i) begin
      tap_q <= RST_TAP;
    end else if (step_i) begin
      tap_q <= up_o ? tap_q + 1'b1 : tap_q - 1'b1;
    end
  end

  // R6
  no_step_at_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !match_o);

  // R5
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_q != $past(tap_q)) && !$past(load_i) |->
      (tap_q == TAP_W'($past(tap_q) + 1'b1)) || (tap_q == TAP_W'($past(tap_q) - 1'b1)));
endmodule

// File: rtl/delay_tap_stepper.sv
module delay_tap_stepper #(
  parameter int TAP_W      = 6,
  parameter int PHASE_CLKS = 2,
  parameter int RD_RST_TAP = 16,
  parameter int WR_RST_TAP = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAP_W-1:0] rd_target_i,
  input  logic [TAP_W-1:0] wr_target_i,
  output logic             rd_rst_o,
  output logic             wr_rst_o,
  output logic             rd_ce_o,
  output logic             wr_ce_o,
  output logic             inc_o,
  output logic             step_clk_o,
  output logic [TAP_W-1:0] rd_tap_o,
  output logic [TAP_W-1:0] wr_tap_o,
  output logic             done_o
);
  import delay_step_pkg::*;

  step_state_e state_q, state_d;
  logic [1:0]  phase;
  logic        pulse_end, run;
  logic        cap, load;
  logic        rd_match, wr_match, rd_up, wr_up;
  logic        rd_move, wr_move;

  assign rd_move = (state_q == ST_RD) && !rd_match;
  assign wr_move = (state_q == ST_WR) && !wr_match;
  assign run     = (state_q == ST_RST) || rd_move || wr_move;
  assign cap     = (state_q == ST_IDLE) && start_i;
  assign load    = (state_q == ST_RST) && pulse_end;

  phase_seq #(.PHASE_CLKS(PHASE_CLKS)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .phase_o (phase),
    .last_o  (pulse_end)
  );

  tap_track #(.TAP_W(TAP_W), .RST_VAL(RD_RST_TAP)) i_rd_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .target_i (rd_target_i),
    .load_i   (load),
    .step_i   (rd_move && pulse_end),
    .tap_o    (rd_tap_o),
    .match_o  (rd_match),
    .up_o     (rd_up)
  );

  tap_track #(.TAP_W(TAP_W), .RST_VAL(WR_RST_TAP)) i_wr_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .target_i (wr_target_i),
    .load_i   (load),
    .step_i   (wr_move && pulse_end),
    .tap_o    (wr_tap_o),
    .match_o  (wr_match),
    .up_o     (wr_up)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_RST;
      ST_RST:  if (pulse_end) state_d = ST_RD;
      ST_RD:   if (rd_match)  state_d = ST_WR;
      ST_WR:   if (wr_match)  state_d = ST_FIN;
      ST_FIN:                 state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rd_rst_o   = (state_q == ST_RST);
  assign wr_rst_o   = (state_q == ST_RST);
  assign rd_ce_o    = rd_move;
  assign wr_ce_o    = wr_move;
  assign inc_o      = (rd_move && rd_up) || (wr_move && wr_up);
  assign step_clk_o = run && (phase == PH_CLK);
  assign done_o     = (state_q == ST_FIN);

  // R4
  one_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ce_o && wr_ce_o));

  // R4
  rd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ce_o |-> rd_match);

  // R4
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ce_o |=> $stable(wr_tap_o));

  // R2
  clk_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_clk_o |-> (rd_rst_o && wr_rst_o) || rd_ce_o || wr_ce_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_match && wr_match);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (state_q != ST_IDLE) |=> !(rd_rst_o && !$past(rd_rst_o)));
endmodule

// File: tb/test_delay_tap_stepper.sv
module test_delay_tap_stepper;
  localparam int TAP_W = 6;
  localparam int P     = 2;

  typedef struct {
    int rd;
    int wr;
    int lat;
    int st;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TAP_W-1:0] rd_tgt = '0;
  logic [TAP_W-1:0] wr_tgt = '0;
  logic             rd_rst, wr_rst, rd_ce, wr_ce, inc, step_clk, done;
  logic [TAP_W-1:0] rd_tap, wr_tap;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   m_rd = 0;
  int   m_wr = 0;
  int   cur_rd = 16;
  int   hi_len = 0;
  int   rst_len = 0;
  logic done_d = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  delay_tap_stepper #(.TAP_W(TAP_W), .PHASE_CLKS(P)) i_delay_tap_stepper (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_target_i(rd_tgt), .wr_target_i(wr_tgt),
    .rd_rst_o(rd_rst), .wr_rst_o(wr_rst), .rd_ce_o(rd_ce), .wr_ce_o(wr_ce),
    .inc_o(inc), .step_clk_o(step_clk),
    .rd_tap_o(rd_tap), .wr_tap_o(wr_tap), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay element model
  always @(posedge step_clk) begin
    if (rd_rst && wr_rst) begin
      m_rd = 16;
      m_wr = 32;
    end else if (rd_ce) begin
      m_rd = inc ? m_rd + 1 : m_rd - 1;
    end else if (wr_ce) begin
      check(m_rd == cur_rd, "R4 write step before read settled", m_rd, cur_rd);
      m_wr = inc ? m_wr + 1 : m_wr - 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_clk) hi_len++;
      else if (hi_len > 0) begin
        check(hi_len == P, "R3 step clock width", hi_len, P);
        hi_len = 0;
      end
      if (rd_rst) rst_len++;
      else if (rst_len > 0) begin
        check(rst_len == 3 * P, "R2 reset pulse length", rst_len, 3 * P);
        rst_len = 0;
      end
      if (done_d) check(!done, "R7 done single cycle", int'(done), 0);
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(rd_tap) == e.rd, "R7 read tap", int'(rd_tap), e.rd);
          check(int'(wr_tap) == e.wr, "R7 write tap", int'(wr_tap), e.wr);
          check(m_rd == e.rd, "R5 read line model", m_rd, e.rd);
          check(m_wr == e.wr, "R5 write line model", m_wr, e.wr);
          check(cyc - e.st == e.lat, "R6 latency", cyc - e.st, e.lat);
        end
      end
      done_d = done;
    end
  end

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic launch(input int r, input int w);
    exp_t e;
    @(negedge clk);
    rd_tgt = TAP_W'(r);
    wr_tgt = TAP_W'(w);
    start  = 1'b1;
    e.rd  = r;
    e.wr  = w;
    e.lat = 3 * P * (1 + absd(r, 16) + absd(w, 32)) + 2;
    e.st  = cyc + 1;
    cur_rd = r;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int r, input int w);
    launch(r, w);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", q.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(int'(rd_tap) == 16, "R1 read tap", int'(rd_tap), 16);
    check(int'(wr_tap) == 32, "R1 write tap", int'(wr_tap), 32);
    check({rd_rst, wr_rst, rd_ce, wr_ce, inc, step_clk, done} == '0, "R1 strobes",
          int'({rd_rst, wr_rst, rd_ce, wr_ce, inc, step_clk, done}), 0);

    // R2 taps right after reset pulse
    launch(16, 32);
    repeat (3 * P) @(negedge clk);
    check(int'(rd_tap) == 16 && int'(wr_tap) == 32, "R2 taps after reset pulse",
          int'(rd_tap), 16);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    run(20, 40);   // R5 up both
    run(10, 25);   // R5 down both
    run(0, 63);    // R6 extremes
    run(63, 0);
    run(16, 5);    // R6 read already at target

    // R8 busy start ignored, target inputs changed mid-run
    launch(5, 50);
    repeat (30) @(negedge clk);
    rd_tgt = 6'd1;
    wr_tgt = 6'd2;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(int'(rd_tap) == 5 && int'(wr_tap) == 50, "R8 taps unchanged after busy start",
          int'(rd_tap), 5);
    check(!rd_rst && !rd_ce && !wr_ce, "R8 idle after busy start",
          int'({rd_rst, rd_ce, wr_ce}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule